// File: doc/BRIEF.md
# One-Time PROM Write-Verify Burn Sequencer

This block sits on the programmer side of a one-time PROM that is reached only through a byte-wide bidirectional data bus, a four-wire mode selector and an address-step clock. The PROM has no address pins. Its internal address moves forward by one after every four step-clock pulses, and it returns to zero in the clear mode. The sequencer powers the part up, clears the address and raises the programming level. It then burns every byte of an image fetched from a byte source. Each byte gets fixed-length write pulses, each followed by a readback. When the readback matches, the byte gets one extra write. The extra write lasts the base pulse length multiplied by the number of pulses the byte needed. The sequencer then steps the address and moves to the next byte. After the last byte it restores the clear mode, lowers the programming level, removes the supplies and reports done.

A second mode programs nothing. It walks the same addresses, compares each readback with the image, and stops at the first difference. A retry limit turns a byte that never verifies into an error that reports its address. All time intervals are cycle counts derived from the system clock frequency parameter. The step-clock half period satisfies both the minimum pulse width and the maximum step-clock frequency of the part.

Top module: `prom_burn_seq`

## Requirements
- R1: After reset and while idle: md_o = 4'b0000 (off), dclk_o low, bus_oe_o low, sup_on_o and prog_lvl_o low, busy_o, done_o, err_o and img_rd_o low.
- R2: A start pulse turns on sup_on_o. md_o stays off and dclk_o stays low for at least SETTLE_CYC cycles. md_o then goes to clear (4'b0110 as {MD3,MD2,MD1,MD0}) with prog_lvl_o low. prog_lvl_o rises while md_o is still clear, and the mode then changes to inhibit (4'b1011). prog_lvl_o is never high without sup_on_o.
- R3: A write pulse drives md_o = 4'b1010 for exactly PULSE_CYC cycles. During the pulse bus_oe_o is high and bus_o carries the image byte. The bus is driven only in the write mode. Inhibit follows the pulse, then verify (4'b1000) with the bus released.
- R4: If the verify readback differs from the image byte, the write, inhibit and verify cycle repeats with a pulse of the same length.
- R5: After a matching verify, one continuous write of N × PULSE_CYC cycles follows, where N is the number of pulses that byte needed. Inhibit comes after it.
- R6: The address advances only through exactly four dclk_o pulses. These pulses occur only in the inhibit mode, and each high phase lasts HALF_CYC = max(ceil(f × 125 ns), ceil(f / 8.38 MHz)) cycles.
- R7: After the step that leaves address last_addr_i, md_o returns to clear. prog_lvl_o then falls, the supplies turn off, and done_o rises with busy_o low. done_o holds until the next start.
- R8: If a byte still fails verify after MAX_TRY pulses, err_o and done_o are set and err_addr_o holds that address. No extra write and no further step follow, and the normal shutdown order applies.
- R9: With verify_only_i high at start, nothing is written. Each byte gets one verify and then a step. The first mismatch sets err_o with its address and ends the run.
- R10: For each byte, img_rd_o pulses for one cycle with img_addr_o equal to the byte index. img_data_i is taken on the following cycle.
- R11: A start pulse while busy_o is high has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run when idle |
| verify_only_i | input | 1 | Run compares only, no writes (taken at start) |
| last_addr_i | input | ADDR_W | Final byte address (taken at start) |
| img_rd_o | output | 1 | Image byte request |
| img_addr_o | output | ADDR_W | Image byte index |
| img_data_i | input | 8 | Image byte, valid the cycle after the request |
| md_o | output | 4 | Mode selector {MD3,MD2,MD1,MD0} |
| dclk_o | output | 1 | Address step clock |
| bus_o | output | 8 | Data driven to the PROM |
| bus_oe_o | output | 1 | Output enable for bus_o |
| bus_i | input | 8 | Data read from the PROM |
| sup_on_o | output | 1 | Supply enable |
| prog_lvl_o | output | 1 | Programming-level enable |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished (sticky) |
| err_o | output | 1 | Run ended on a failure (sticky) |
| err_addr_o | output | ADDR_W | Address of the failure |

## Verification
The hardest situations to reach are the retry cap and the first-mismatch stop, because each needs a PROM that refuses to take a byte or holds the wrong one. The bench models the PROM: it counts step pulses to track the address and counts write pulses per cell. It gives each address a required pulse count of 1 to 3, so every byte needs a different number of retries and a different extra-write length. For the error runs, the bench gives one cell an impossible pulse count, or changes one image byte after burning, so the block reaches its failure path at a known address.

// File: rtl/prom_burn_pkg.sv
package prom_burn_pkg;

   // Mode selector values, bit order {MD3,MD2,MD1,MD0}
   typedef enum logic [3:0] {
      MD_OFF     = 4'b0000,
      MD_VERIFY  = 4'b1000,
      MD_WRITE   = 4'b1010,
      MD_INHIBIT = 4'b1011,
      MD_CLEAR   = 4'b0110
   } md_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_SETTLE, ST_CLEAR, ST_RAISE, ST_INH0, ST_FETCH, ST_LOAD,
      ST_WRITE, ST_POSTW, ST_VERIFY, ST_EXTRA, ST_POSTX, ST_STEP,
      ST_FINCLR, ST_FINDROP
   } seq_st_e;

   // Rounded-up cycle count for an interval in nanoseconds, at least 1
   function automatic int unsigned cyc_of_ns(int unsigned hz, longint unsigned ns);
      longint unsigned p;
      longint unsigned c;
      p = longint'(hz) * ns;
      c = (p + 64'd999_999_999) / 64'd1_000_000_000;
      if (c == 0) c = 1;
      return int'(c);
   endfunction

   // Step-clock half period: minimum width and maximum frequency both met
   function automatic int unsigned half_cyc(int unsigned hz);
      int unsigned a;
      int unsigned b;
      a = cyc_of_ns(hz, 64'd125);
      b = int'((longint'(hz) + 64'd8_379_999) / 64'd8_380_000);
      if (b > a) a = b;
      if (a == 0) a = 1;
      return a;
   endfunction

endpackage

// File: rtl/prom_burn_timer.sv
module prom_burn_timer #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (ld)            cnt_q <= ld_val - 1'b1;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/prom_burn_clkgen.sv
module prom_burn_clkgen #(
   parameter int unsigned HALF   = 2,
   parameter int unsigned NPULSE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic dclk,
   output logic fin
);
   localparam int unsigned HW = $clog2(HALF + 1);
   localparam int unsigned PW = $clog2(NPULSE + 1);

   logic          act_q;
   logic [HW-1:0] hcnt_q;
   logic [PW-1:0] pcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         hcnt_q <= '0;
         pcnt_q <= '0;
         dclk   <= 1'b0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            act_q  <= 1'b1;
            dclk   <= 1'b1;
            hcnt_q <= HW'(HALF - 1);
            pcnt_q <= '0;
         end else if (act_q) begin
            if (hcnt_q != '0) begin
               hcnt_q <= hcnt_q - 1'b1;
            end else if (dclk) begin
               dclk   <= 1'b0;
               hcnt_q <= HW'(HALF - 1);
            end else if (pcnt_q == PW'(NPULSE - 1)) begin
               act_q <= 1'b0;
               fin   <= 1'b1;
            end else begin
               pcnt_q <= pcnt_q + 1'b1;
               dclk   <= 1'b1;
               hcnt_q <= HW'(HALF - 1);
            end
         end
      end
   end
endmodule

// File: rtl/prom_burn_sync.sv
module prom_burn_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe_q [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      pipe_q[i] <= '0;
               else if (i == 0) pipe_q[i] <= d;
               else             pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
            end
         end
         assign q = pipe_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/prom_burn_seq.sv
module prom_burn_seq
   import prom_burn_pkg::*;
#(
   parameter int unsigned SYS_HZ      = 50_000_000,
   parameter int unsigned ADDR_W      = 15,
   parameter int unsigned PULSE_US    = 1000,
   parameter int unsigned SETTLE_US   = 10,
   parameter int unsigned GAP_NS      = 2000,
   parameter int unsigned MAX_TRY     = 25,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              verify_only_i,
   input  logic [ADDR_W-1:0] last_addr_i,
   output logic              img_rd_o,
   output logic [ADDR_W-1:0] img_addr_o,
   input  logic [7:0]        img_data_i,
   output logic [3:0]        md_o,
   output logic              dclk_o,
   output logic [7:0]        bus_o,
   output logic              bus_oe_o,
   input  logic [7:0]        bus_i,
   output logic              sup_on_o,
   output logic              prog_lvl_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [ADDR_W-1:0] err_addr_o
);
   localparam int unsigned PULSE_CYC  = cyc_of_ns(SYS_HZ, longint'(PULSE_US) * 1000);
   localparam int unsigned SETTLE_CYC = cyc_of_ns(SYS_HZ, longint'(SETTLE_US) * 1000);
   localparam int unsigned GAP_CYC    = cyc_of_ns(SYS_HZ, longint'(GAP_NS));
   localparam int unsigned HALF_CYC   = half_cyc(SYS_HZ);
   localparam int unsigned MAX_A      = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
   localparam int unsigned MAX_CYC    = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
   localparam int unsigned TW         = $clog2(MAX_CYC + 1);
   localparam int unsigned TRW        = $clog2(MAX_TRY + 1);

   generate
      if (MAX_TRY < 1) begin : g_bad_try
         $error("MAX_TRY must be at least 1");
      end
      if (GAP_CYC <= SYNC_STAGES) begin : g_bad_gap
         $error("verify window must exceed the readback synchroniser depth");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   seq_st_e           st_q, st_d;
   logic              tmr_ld, tmr_zero;
   logic [TW-1:0]     tmr_val;
   logic              ck_go, ck_fin;
   logic [7:0]        rb;
   logic              vonly_q;
   logic [ADDR_W-1:0] last_q, addr_q;
   logic [7:0]        data_q;
   logic [TRW-1:0]    try_q, xleft_q;
   logic              rb_match, give_up;

   prom_burn_timer #(.W(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .ld(tmr_ld), .ld_val(tmr_val), .zero(tmr_zero)
   );

   prom_burn_clkgen #(.HALF(HALF_CYC), .NPULSE(4)) u_ck (
      .clk(clk), .rst_n(rst_n), .go(ck_go), .dclk(dclk_o), .fin(ck_fin)
   );

   prom_burn_sync #(.WIDTH(8), .STAGES(SYNC_STAGES)) u_rb (
      .clk(clk), .rst_n(rst_n), .d(bus_i), .q(rb)
   );

   assign rb_match = (rb == data_q);
   assign give_up  = vonly_q || (try_q == TRW'(MAX_TRY));

   always_comb begin
      st_d     = st_q;
      tmr_ld   = 1'b0;
      tmr_val  = TW'(GAP_CYC);
      ck_go    = 1'b0;
      img_rd_o = 1'b0;
      unique case (st_q)
         ST_IDLE:    if (start_i) begin
                        st_d = ST_SETTLE; tmr_ld = 1'b1; tmr_val = TW'(SETTLE_CYC);
                     end
         ST_SETTLE:  if (tmr_zero) begin st_d = ST_CLEAR; tmr_ld = 1'b1; end
         ST_CLEAR:   if (tmr_zero) begin st_d = ST_RAISE; tmr_ld = 1'b1; end
         ST_RAISE:   if (tmr_zero) begin st_d = ST_INH0;  tmr_ld = 1'b1; end
         ST_INH0:    if (tmr_zero) st_d = ST_FETCH;
         ST_FETCH:   begin img_rd_o = 1'b1; st_d = ST_LOAD; end
         ST_LOAD:    begin
                        tmr_ld = 1'b1;
                        if (vonly_q) st_d = ST_VERIFY;
                        else begin st_d = ST_WRITE; tmr_val = TW'(PULSE_CYC); end
                     end
         ST_WRITE:   if (tmr_zero) begin st_d = ST_POSTW; tmr_ld = 1'b1; end
         ST_POSTW:   if (tmr_zero) begin st_d = ST_VERIFY; tmr_ld = 1'b1; end
         ST_VERIFY:  if (tmr_zero) begin
                        if (rb_match && vonly_q) begin
                           st_d = ST_STEP; ck_go = 1'b1;
                        end else if (rb_match) begin
                           st_d = ST_EXTRA; tmr_ld = 1'b1; tmr_val = TW'(PULSE_CYC);
                        end else if (give_up) begin
                           st_d = ST_FINCLR; tmr_ld = 1'b1;
                        end else begin
                           st_d = ST_WRITE; tmr_ld = 1'b1; tmr_val = TW'(PULSE_CYC);
                        end
                     end
         ST_EXTRA:   if (tmr_zero) begin
                        tmr_ld = 1'b1;
                        if (xleft_q == TRW'(1)) st_d = ST_POSTX;
                        else tmr_val = TW'(PULSE_CYC);
                     end
         ST_POSTX:   if (tmr_zero) begin st_d = ST_STEP; ck_go = 1'b1; end
         ST_STEP:    if (ck_fin) begin
                        if (addr_q == last_q) begin st_d = ST_FINCLR; tmr_ld = 1'b1; end
                        else st_d = ST_FETCH;
                     end
         ST_FINCLR:  if (tmr_zero) begin st_d = ST_FINDROP; tmr_ld = 1'b1; end
         ST_FINDROP: if (tmr_zero) st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         vonly_q    <= 1'b0;
         last_q     <= '0;
         addr_q     <= '0;
         data_q     <= '0;
         try_q      <= '0;
         xleft_q    <= '0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
         err_addr_o <= '0;
      end else begin
         st_q <= st_d;
         case (st_q)
            ST_IDLE: if (start_i) begin
               vonly_q    <= verify_only_i;
               last_q     <= last_addr_i;
               addr_q     <= '0;
               done_o     <= 1'b0;
               err_o      <= 1'b0;
               err_addr_o <= '0;
            end
            ST_LOAD: begin
               data_q <= img_data_i;
               try_q  <= vonly_q ? TRW'(0) : TRW'(1);
            end
            ST_VERIFY: if (tmr_zero) begin
               if (rb_match)     xleft_q <= try_q;
               else if (give_up) begin
                  err_o      <= 1'b1;
                  err_addr_o <= addr_q;
               end else          try_q <= try_q + 1'b1;
            end
            ST_EXTRA: if (tmr_zero && xleft_q != TRW'(1)) xleft_q <= xleft_q - 1'b1;
            ST_STEP: if (ck_fin && addr_q != last_q) addr_q <= addr_q + 1'b1;
            ST_FINDROP: if (tmr_zero) done_o <= 1'b1;
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (st_q)
         ST_IDLE, ST_SETTLE:              md_o = MD_OFF;
         ST_CLEAR, ST_RAISE,
         ST_FINCLR, ST_FINDROP:           md_o = MD_CLEAR;
         ST_WRITE, ST_EXTRA:              md_o = MD_WRITE;
         ST_VERIFY:                       md_o = MD_VERIFY;
         default:                         md_o = MD_INHIBIT;
      endcase
   end

   assign img_addr_o = addr_q;
   assign bus_o      = data_q;
   assign bus_oe_o   = (st_q == ST_WRITE) || (st_q == ST_EXTRA);
   assign busy_o     = (st_q != ST_IDLE);
   assign sup_on_o   = (st_q != ST_IDLE);
   assign prog_lvl_o = !(st_q inside {ST_IDLE, ST_SETTLE, ST_CLEAR, ST_FINDROP});
endmodule

// File: rtl/prom_burn_seq_chk.sv
module prom_burn_seq_chk
   import prom_burn_pkg::*;
#(
   parameter int unsigned HALF_CYC  = 2,
   parameter int unsigned PULSE_CYC = 2,
   parameter int unsigned MAX_TRY   = 4,
   parameter int unsigned TRW       = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic [3:0]     md_o,
   input logic           dclk_o,
   input logic           bus_oe_o,
   input logic           sup_on_o,
   input logic           prog_lvl_o,
   input logic           busy_o,
   input logic           done_o,
   input logic [TRW-1:0] tries
);
   logic [15:0] hi_len;
   logic [31:0] wr_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len <= '0;
         wr_len <= '0;
      end else begin
         hi_len <= dclk_o ? ((hi_len == 16'hFFFF) ? hi_len : hi_len + 1'b1) : '0;
         wr_len <= (md_o == MD_WRITE) ? wr_len + 1'b1 : '0;
      end
   end

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (md_o == MD_OFF && !sup_on_o && !bus_oe_o)); // R1
   AST_LEVEL_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      prog_lvl_o |-> sup_on_o); // R2
   AST_DRIVE_ONLY_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_o |-> (md_o == MD_WRITE)); // R3
   AST_WRITE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (md_o != MD_WRITE && $past(md_o) == MD_WRITE) |-> (wr_len >= PULSE_CYC)); // R3
   AST_STEP_IN_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
      dclk_o |-> (md_o == MD_INHIBIT)); // R6
   AST_STEP_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dclk_o) |-> (hi_len >= HALF_CYC)); // R6
   AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R7
   AST_TRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      tries <= TRW'(MAX_TRY)); // R8
endmodule

bind prom_burn_seq prom_burn_seq_chk #(
   .HALF_CYC(HALF_CYC), .PULSE_CYC(PULSE_CYC), .MAX_TRY(MAX_TRY), .TRW(TRW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .md_o(md_o), .dclk_o(dclk_o), .bus_oe_o(bus_oe_o),
   .sup_on_o(sup_on_o), .prog_lvl_o(prog_lvl_o), .busy_o(busy_o),
   .done_o(done_o), .tries(try_q)
);

// File: tb/prom_burn_seq_tb.sv
`timescale 1ns/1ps
module prom_burn_seq_tb;
   localparam int AW     = 6;
   localparam int PULSE  = 200;  // 1 us at 200 MHz
   localparam int SETTLE = 200;  // 1 us
   localparam int HALF   = 25;   // max(ceil(200M*125ns), ceil(200M/8.38M))
   localparam int TRIES  = 4;
   localparam logic [3:0] M_OFF = 4'b0000, M_CLR = 4'b0110, M_WR = 4'b1010,
                          M_VF = 4'b1000, M_INH = 4'b1011;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, vonly = 1'b0;
   logic [AW-1:0] last_addr = '0;
   logic img_rd, dclk, bus_oe, sup_on, prog_lvl, busy, done, err;
   logic [AW-1:0] img_addr, err_addr;
   logic [7:0] img_data = 8'h00, bus_o, bus_i = 8'h00;
   logic [3:0] md;

   always #2.5 clk = ~clk;

   prom_burn_seq #(.SYS_HZ(200_000_000), .ADDR_W(AW), .PULSE_US(1), .SETTLE_US(1),
                   .GAP_NS(50), .MAX_TRY(TRIES), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .verify_only_i(vonly),
      .last_addr_i(last_addr), .img_rd_o(img_rd), .img_addr_o(img_addr),
      .img_data_i(img_data), .md_o(md), .dclk_o(dclk), .bus_o(bus_o),
      .bus_oe_o(bus_oe), .bus_i(bus_i), .sup_on_o(sup_on), .prog_lvl_o(prog_lvl),
      .busy_o(busy), .done_o(done), .err_o(err), .err_addr_o(err_addr));

   int n_chk = 0, n_bad = 0;
   int flip_addr = -1, fail_addr = -1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] img_f(int a);
      return 8'(a * 37 + 11) ^ ((a == flip_addr) ? 8'h3C : 8'h00);
   endfunction
   function automatic int hard_f(int a);
      return (a == fail_addr) ? 99 : (a % 3) + 1;
   endfunction

   // PROM model
   int wcount [64];
   logic [7:0] mem [64];
   int dev_addr = 0, pcount = 0;

   // scoreboard
   typedef struct { int addr; int tries; } item_t;
   item_t q[$];

   // per-address observations
   int run_len = 0, last_len = 0, wr_cnt = 0, vf_cnt = 0, seq_bad = 0, data_bad = 0;
   int clr_cnt = 0, sup_cnt = 0, hi_len = 0, hi_min = 1000, hi_max = 0;
   logic [7:0] wr_data = 8'h00;
   logic [3:0] md_prev = 4'b0000;
   logic dclk_prev = 1'b0;

   task automatic clear_stats();
      run_len = 0; last_len = 0; wr_cnt = 0; vf_cnt = 0; seq_bad = 0; data_bad = 0;
   endtask

   task automatic step_event();
      item_t e;
      if (q.size() == 0) begin
         chk(0, "R6 step with no expected byte", dev_addr, -1);
      end else begin
         e = q.pop_front();
         chk(dev_addr == e.addr, "R6 stepped address", dev_addr, e.addr);
         if (e.tries == 0) begin
            chk(wr_cnt == 0, "R9 no write in compare mode", wr_cnt, 0);
            chk(vf_cnt == 1, "R9 one verify per byte", vf_cnt, 1);
         end else begin
            chk(wr_cnt == e.tries + 1 && seq_bad == 0, "R4 write pulses per byte", wr_cnt, e.tries + 1);
            chk(last_len == e.tries * PULSE, "R5 extra write length", last_len, e.tries * PULSE);
            chk(data_bad == 0, "R3 R10 write data equals image byte", data_bad, 0);
         end
      end
      clear_stats();
      dev_addr++;
      pcount = 0;
   endtask

   // monitor, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (md == M_WR) begin
            run_len++;
            if (!bus_oe || bus_o !== img_f(dev_addr)) data_bad = 1;
            wr_data = bus_o;
         end else if (md_prev == M_WR) begin
            if (wr_cnt > 0 && last_len != PULSE) seq_bad = 1;
            last_len = run_len; run_len = 0; wr_cnt++;
            wcount[dev_addr]++;
            if (wcount[dev_addr] == hard_f(dev_addr)) mem[dev_addr] = wr_data;
         end
         if (md == M_VF && md_prev != M_VF) vf_cnt++;
         if (md == M_CLR && md_prev != M_CLR) clr_cnt++;
         if (md == M_CLR) begin dev_addr = 0; pcount = 0; end
         if (sup_on && md == M_OFF) sup_cnt++;
         if (md == M_CLR && md_prev == M_OFF) begin
            chk(sup_cnt >= SETTLE && !prog_lvl, "R2 settle before clear", sup_cnt, SETTLE);
            sup_cnt = 0;
         end
         if (md == M_INH && md_prev == M_CLR)
            chk(prog_lvl == 1'b1, "R2 level raised before inhibit", prog_lvl, 1);
         if (dclk) hi_len++;
         else if (dclk_prev) begin
            if (hi_len < hi_min) hi_min = hi_len;
            if (hi_len > hi_max) hi_max = hi_len;
            hi_len = 0;
            pcount++;
            if (pcount == 4) step_event();
         end
         bus_i = (md == M_VF) ? ((wcount[dev_addr] >= hard_f(dev_addr)) ? mem[dev_addr] : 8'hFF)
                              : 8'h00;
         img_data = img_f(int'(img_addr));
         md_prev = md;
         dclk_prev = dclk;
      end
   end

   task automatic reset_model();
      for (int i = 0; i < 64; i++) begin wcount[i] = 0; mem[i] = 8'hFF; end
   endtask

   task automatic push_items(input bit compare, input int last, input int stop_at);
      for (int a = 0; a <= last; a++) begin
         item_t e;
         if (a == stop_at) break;
         e.addr = a;
         e.tries = compare ? 0 : hard_f(a);
         q.push_back(e);
      end
   endtask

   task automatic run(input bit compare, input int last, input int exp_err, input bit spurious);
      int n = 0;
      clear_stats(); clr_cnt = 0; sup_cnt = 0; hi_min = 1000; hi_max = 0;
      push_items(compare, last, exp_err);
      @(negedge clk);
      vonly = compare; last_addr = AW'(last); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 60000) begin
         @(negedge clk);
         n++;
         if (spurious && n == 3000) start = 1'b1;   // R11: ignored while busy
         else start = 1'b0;
      end
      start = 1'b0;
      chk(done == 1'b1, "R7 run completes", done, 1);
      chk(busy == 1'b0 && sup_on == 1'b0 && prog_lvl == 1'b0 && md == M_OFF,
          "R7 supplies removed at end", {busy, sup_on, prog_lvl}, 0);
      chk(err == (exp_err >= 0), "R8 R9 error flag", err, exp_err >= 0);
      if (exp_err >= 0) chk(err_addr == AW'(exp_err), "R8 R9 error address", err_addr, exp_err);
      chk(q.size() == 0, "R6 every expected step seen", q.size(), 0);
      chk(clr_cnt == 2, "R11 R7 one clear at start and one at end", clr_cnt, 2);
      if (hi_max > 0) chk(hi_min == HALF && hi_max == HALF, "R6 step clock high width", hi_min, HALF);
      q.delete();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      reset_model();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(md == M_OFF && !dclk && !bus_oe && !sup_on && !prog_lvl, "R1 idle outputs",
          {md, dclk, bus_oe, sup_on, prog_lvl}, 0);
      chk(!busy && !done && !err && !img_rd, "R1 idle status", {busy, done, err, img_rd}, 0);

      // burn six bytes, needing 1..3 pulses each, with a stray start mid-run
      run(1'b0, 5, -1, 1'b1);
      // compare the burnt image: all good
      run(1'b1, 5, -1, 1'b0);
      // compare against an image that differs at byte 3
      flip_addr = 3;
      run(1'b1, 5, 3, 1'b0);
      chk(vf_cnt == 1 && wr_cnt == 0, "R9 stop at first mismatch", vf_cnt, 1);
      flip_addr = -1;
      // fresh part with a cell at byte 2 that never takes
      reset_model();
      fail_addr = 2;
      run(1'b0, 4, 2, 1'b0);
      chk(wr_cnt == TRIES, "R8 pulse count before giving up", wr_cnt, TRIES);
      chk(last_len == PULSE && seq_bad == 0, "R8 no extra write after failure", last_len, PULSE);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule